// File: doc/BRIEF.md
# MSI Doorbell Device-ID Window Translator

This block sits in the write path in front of an interrupt translation unit. It turns writes that land in an aliased address window into tagged doorbell writes. The requester's device ID is not carried on a sideband signal. The block recovers it from where the write falls inside the window: each device owns one 32-bit word slot at `base + (id << 2)`. The forwarded doorbell carries the original data together with that ID. A write aimed directly at the translation register address is forwarded with ID zero. Any other write is passed unchanged to a bypass output.

The window base and size come in on configuration ports. The usable number of ID bits follows from the window size and is capped at the width the downstream unit supports. A window whose size cannot be decoded is treated as switched off. Inside the window, only full, aligned 32-bit writes are translated. Any other write into the window is dropped and raises a one-cycle error pulse.

Top module: `msi_devid_xlate`

## Requirements
- R1: After reset, `db_valid`, `byp_valid` and `err_pulse` are low and stay low until a write is accepted.
- R2: An accepted full aligned write (strobes 4'hF, address bits [1:0] zero) whose offset `addr - cfg_win_base` is below the window span appears on the doorbell output in the next cycle. It carries the unchanged data and `db_devid` equal to offset bits [N+1:2].
- R3: N equals log2(`cfg_win_size`) - 2, capped at `DEVID_W`. The window span is 4 << N bytes, so with the cap a write at or beyond `base + (4 << DEVID_W)` is not in the window.
- R4: An accepted write to address `XLATE_ADDR` that is not in the window appears on the doorbell output in the next cycle with `db_devid` 0 and the data unchanged.
- R5: An accepted in-window write that is not full and aligned is never forwarded. In the next cycle it raises `err_pulse` for exactly that cycle.
- R6: A `cfg_win_size` that is not a power of two, or is below 8, disables the window. Writes into that range then go to bypass, while direct writes to `XLATE_ADDR` are still forwarded with ID 0.
- R7: An accepted write that is neither in the window nor aimed at `XLATE_ADDR` appears on the bypass output in the next cycle, with address, data and strobes unchanged.
- R8: While an output is valid and not ready, its payload is held stable and `in_ready` stays low.
- R9: When `XLATE_ADDR` falls inside an enabled window, a write there is decoded as a window write, with ID taken from its offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_win_base | input | 32 | Window base address |
| cfg_win_size | input | 32 | Window size in bytes |
| in_valid | input | 1 | Write request valid |
| in_ready | output | 1 | Write request accepted when high with in_valid |
| in_addr | input | 32 | Write byte address |
| in_data | input | 32 | Write data |
| in_strb | input | 4 | Byte strobes |
| db_valid | output | 1 | Doorbell write valid |
| db_ready | input | 1 | Doorbell consumer ready |
| db_devid | output | DEVID_W | Recovered device ID |
| db_data | output | 32 | Doorbell data |
| byp_valid | output | 1 | Bypass write valid |
| byp_ready | input | 1 | Bypass consumer ready |
| byp_addr | output | 32 | Bypass address |
| byp_data | output | 32 | Bypass data |
| byp_strb | output | 4 | Bypass strobes |
| err_pulse | output | 1 | One-cycle flag for a dropped malformed window write |

## Verification
The assertions check on every cycle that both outputs hold their payload while stalled, that a stall on either output blocks the input, that an error pulse follows only an accepted write, and that all outputs are idle after reset. Whether the right ID is extracted is something only the bench scenarios can show. The same goes for the cap on ID bits, the window edges, disabled-size decoding, the priority of the window over the direct address, and whether a write is classed as doorbell, bypass or error. All of these depend on configuration values that the checker does not model.

// File: rtl/msi_xlate_pkg.sv
// Package: shared classification type and size helper for the window translator.
// Assumes 32-bit addresses and data.
package msi_xlate_pkg;

    // Outcome of decoding one incoming write
    typedef enum logic [1:0] {
        CLS_BYPASS = 2'd0,
        CLS_WIN    = 2'd1,
        CLS_DIRECT = 2'd2,
        CLS_BAD    = 2'd3
    } wr_class_e;

    // Index of the highest set bit (0 for input 0)
    function automatic logic [5:0] floor_log2(input logic [31:0] v);
        logic [5:0] r;
        r = 6'd0;
        for (int i = 0; i < 32; i++) begin
            if (v[i]) r = 6'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/msi_win_cfg.sv
// Module: derives window enable, ID bit count and span from the size input.
// Assumes DEVID_W <= 29 so the span fits in 33 bits.
module msi_win_cfg #(
    parameter int DEVID_W = 16
) (
    input  logic [31:0] win_size,
    output logic        win_en,
    output logic [5:0]  id_bits,
    output logic [32:0] win_span
);
    import msi_xlate_pkg::*;

    localparam logic [5:0] MAX_BITS = 6'(DEVID_W);

    logic       is_pow2;
    logic [5:0] lg;
    logic [5:0] raw_bits;

    // Decode size into enable, capped ID width and byte span
    always_comb begin
        is_pow2  = (win_size != 32'd0) && ((win_size & (win_size - 32'd1)) == 32'd0);
        lg       = floor_log2(win_size);
        win_en   = is_pow2 && (lg >= 6'd3);
        raw_bits = win_en ? (lg - 6'd2) : 6'd0;
        id_bits  = (raw_bits > MAX_BITS) ? MAX_BITS : raw_bits;
        win_span = win_en ? (33'd4 << id_bits) : 33'd0;
    end
endmodule

// File: rtl/msi_win_decode.sv
// Module: classifies one write against the window and the direct doorbell address,
// and extracts the device ID from the window offset. Window match wins over direct.
module msi_win_decode #(
    parameter int          DEVID_W    = 16,
    parameter logic [31:0] XLATE_ADDR = 32'h0801_0040
) (
    input  logic [31:0]               addr,
    input  logic [3:0]                strb,
    input  logic [31:0]               win_base,
    input  logic                      win_en,
    input  logic [5:0]                id_bits,
    input  logic [32:0]               win_span,
    output msi_xlate_pkg::wr_class_e  cls,
    output logic [DEVID_W-1:0]        devid
);
    import msi_xlate_pkg::*;

    logic [31:0]        offset;
    logic               in_win;
    logic               full_word;
    logic [DEVID_W-1:0] id_mask;

    // Offset, window match and access shape
    always_comb begin
        offset    = addr - win_base;
        in_win    = win_en && ({1'b0, offset} < win_span);
        full_word = (strb == 4'hF) && (addr[1:0] == 2'b00);
        id_mask   = ~({DEVID_W{1'b1}} << id_bits);
        devid     = offset[DEVID_W+1:2] & id_mask;
    end

    // Priority decode: window, then direct register, then bypass
    always_comb begin
        if (in_win)                cls = full_word ? CLS_WIN : CLS_BAD;
        else if (addr == XLATE_ADDR) cls = CLS_DIRECT;
        else                       cls = CLS_BYPASS;
    end
endmodule

// File: rtl/msi_out_slice.sv
// Module: single-entry valid/ready output register; payload held until taken.
// Assumes the parent loads only when the slot is empty or draining.
module msi_out_slice #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    input  logic         ready,
    output logic         valid,
    output logic [W-1:0] dout
);
    // Track occupancy of the slot
    always_ff @(posedge clk) begin
        if (!rst_n)     valid <= 1'b0;
        else if (load)  valid <= 1'b1;
        else if (ready) valid <= 1'b0;
    end

    // Capture payload on load only
    always_ff @(posedge clk) begin
        if (!rst_n)    dout <= '0;
        else if (load) dout <= din;
    end
endmodule

// File: rtl/msi_devid_xlate.sv
// Module: top of the doorbell device-ID translator. Routes each accepted write to
// the doorbell slice, the bypass slice, or drops it with an error pulse.
// Assumes cfg inputs are quasi-static while writes are in flight.
module msi_devid_xlate #(
    parameter int          DEVID_W    = 16,
    parameter logic [31:0] XLATE_ADDR = 32'h0801_0040
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [31:0]        cfg_win_base,
    input  logic [31:0]        cfg_win_size,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [31:0]        in_addr,
    input  logic [31:0]        in_data,
    input  logic [3:0]         in_strb,
    output logic               db_valid,
    input  logic               db_ready,
    output logic [DEVID_W-1:0] db_devid,
    output logic [31:0]        db_data,
    output logic               byp_valid,
    input  logic               byp_ready,
    output logic [31:0]        byp_addr,
    output logic [31:0]        byp_data,
    output logic [3:0]         byp_strb,
    output logic               err_pulse
);
    import msi_xlate_pkg::*;

    localparam int DB_W  = DEVID_W + 32;
    localparam int BYP_W = 32 + 32 + 4;

    logic               win_en;
    logic [5:0]         id_bits;
    logic [32:0]        win_span;
    wr_class_e          cls;
    logic [DEVID_W-1:0] dec_id;
    logic               accept;
    logic               db_load, byp_load;
    logic [DB_W-1:0]    db_din, db_dout;
    logic [BYP_W-1:0]   byp_din, byp_dout;

    msi_win_cfg #(.DEVID_W(DEVID_W)) u_cfg (
        .win_size (cfg_win_size),
        .win_en   (win_en),
        .id_bits  (id_bits),
        .win_span (win_span)
    );

    msi_win_decode #(.DEVID_W(DEVID_W), .XLATE_ADDR(XLATE_ADDR)) u_dec (
        .addr     (in_addr),
        .strb     (in_strb),
        .win_base (cfg_win_base),
        .win_en   (win_en),
        .id_bits  (id_bits),
        .win_span (win_span),
        .cls      (cls),
        .devid    (dec_id)
    );

    // Accept only when both output slots can take a new entry
    always_comb begin
        in_ready = (!db_valid || db_ready) && (!byp_valid || byp_ready);
        accept   = in_valid && in_ready;
        db_load  = accept && ((cls == CLS_WIN) || (cls == CLS_DIRECT));
        byp_load = accept && (cls == CLS_BYPASS);
        db_din   = {(cls == CLS_WIN) ? dec_id : {DEVID_W{1'b0}}, in_data};
        byp_din  = {in_addr, in_data, in_strb};
    end

    msi_out_slice #(.W(DB_W)) u_db (
        .clk (clk), .rst_n (rst_n), .load (db_load), .din (db_din),
        .ready (db_ready), .valid (db_valid), .dout (db_dout)
    );

    msi_out_slice #(.W(BYP_W)) u_byp (
        .clk (clk), .rst_n (rst_n), .load (byp_load), .din (byp_din),
        .ready (byp_ready), .valid (byp_valid), .dout (byp_dout)
    );

    // Split slice payloads onto the ports
    always_comb begin
        db_devid = db_dout[DB_W-1:32];
        db_data  = db_dout[31:0];
        byp_addr = byp_dout[BYP_W-1:36];
        byp_data = byp_dout[35:4];
        byp_strb = byp_dout[3:0];
    end

    // One-cycle error flag for a dropped malformed window write
    always_ff @(posedge clk) begin
        if (!rst_n) err_pulse <= 1'b0;
        else        err_pulse <= accept && (cls == CLS_BAD);
    end
endmodule

// File: rtl/msi_devid_xlate_chk.sv
// Module: protocol checker bound to the translator top.
module msi_devid_xlate_chk #(
    parameter int DEVID_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic               in_ready,
    input logic               db_valid,
    input logic               db_ready,
    input logic [DEVID_W-1:0] db_devid,
    input logic [31:0]        db_data,
    input logic               byp_valid,
    input logic               byp_ready,
    input logic [31:0]        byp_addr,
    input logic [31:0]        byp_data,
    input logic [3:0]         byp_strb,
    input logic               err_pulse
);
    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!db_valid && !byp_valid && !err_pulse)); // R1

    AST_DB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (db_valid && !db_ready) |=> (db_valid && $stable(db_devid) && $stable(db_data))); // R8

    AST_BYP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (byp_valid && !byp_ready) |=> (byp_valid && $stable(byp_addr) && $stable(byp_data) && $stable(byp_strb))); // R8

    AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        ((db_valid && !db_ready) || (byp_valid && !byp_ready)) |-> !in_ready); // R8

    AST_ERR_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> $past(in_valid && in_ready)); // R5
endmodule

bind msi_devid_xlate msi_devid_xlate_chk #(.DEVID_W(DEVID_W)) u_chk (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_ready (in_ready),
    .db_valid (db_valid), .db_ready (db_ready), .db_devid (db_devid), .db_data (db_data),
    .byp_valid (byp_valid), .byp_ready (byp_ready), .byp_addr (byp_addr),
    .byp_data (byp_data), .byp_strb (byp_strb), .err_pulse (err_pulse)
);

// File: tb/tb_msi_devid_xlate.sv
module tb_msi_devid_xlate;
    localparam int          DEVID_W = 16;
    localparam logic [31:0] XADDR   = 32'h0801_0040;
    localparam logic [1:0]  K_DB = 2'd0, K_BYP = 2'd1, K_ERR = 2'd2;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [31:0]        cfg_win_base = '0, cfg_win_size = '0;
    logic               in_valid = 1'b0;
    logic               in_ready;
    logic [31:0]        in_addr = '0, in_data = '0;
    logic [3:0]         in_strb = '0;
    logic               db_valid, db_ready = 1'b1;
    logic [DEVID_W-1:0] db_devid;
    logic [31:0]        db_data;
    logic               byp_valid, byp_ready = 1'b1;
    logic [31:0]        byp_addr, byp_data;
    logic [3:0]         byp_strb;
    logic               err_pulse;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    msi_devid_xlate #(.DEVID_W(DEVID_W), .XLATE_ADDR(XADDR)) dut (.*);

    typedef struct packed {
        logic [31:0] base;
        logic [31:0] size;
        logic [31:0] addr;
        logic [31:0] data;
        logic [3:0]  strb;
        logic [1:0]  kind;
        logic [15:0] id;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{32'h1000_0000, 32'h400,     32'h1000_0000, 32'hA000_0001, 4'hF, K_DB,  16'h0000, 8'd2}, // R2 first slot
        '{32'h1000_0000, 32'h400,     32'h1000_03FC, 32'hA000_0002, 4'hF, K_DB,  16'h00FF, 8'd2}, // R2 last slot
        '{32'h1000_0000, 32'h400,     32'h1000_0124, 32'hA000_0003, 4'hF, K_DB,  16'h0049, 8'd2}, // R2 middle
        '{32'h1000_0000, 32'h400,     32'h1000_0400, 32'hA000_0004, 4'hF, K_BYP, 16'h0000, 8'd7}, // R7 just past window
        '{32'h1000_0000, 32'h400,     32'h0FFF_FFFC, 32'hA000_0005, 4'hF, K_BYP, 16'h0000, 8'd7}, // R7 just below base
        '{32'h1000_0000, 32'h400,     XADDR,         32'hA000_0006, 4'hF, K_DB,  16'h0000, 8'd4}, // R4 direct
        '{32'h1000_0000, 32'h400,     32'h1000_0010, 32'hA000_0007, 4'h3, K_ERR, 16'h0000, 8'd5}, // R5 partial strobes
        '{32'h1000_0000, 32'h400,     32'h1000_0012, 32'hA000_0008, 4'hF, K_ERR, 16'h0000, 8'd5}, // R5 misaligned
        '{32'h1000_0000, 32'h400,     32'h2000_0000, 32'hA000_0009, 4'h5, K_BYP, 16'h0000, 8'd7}, // R7 unrelated
        '{32'h1000_0000, 32'h300,     32'h1000_0008, 32'hA000_000A, 4'hF, K_BYP, 16'h0000, 8'd6}, // R6 non power of two
        '{32'h1000_0000, 32'h4,       32'h1000_0000, 32'hA000_000B, 4'hF, K_BYP, 16'h0000, 8'd6}, // R6 too small
        '{32'h1000_0000, 32'h4,       XADDR,         32'hA000_000C, 4'hF, K_DB,  16'h0000, 8'd6}, // R6 direct still works
        '{32'h2000_0000, 32'h40_0000, 32'h2004_0000, 32'hA000_000D, 4'hF, K_BYP, 16'h0000, 8'd3}, // R3 beyond capped span
        '{32'h2000_0000, 32'h40_0000, 32'h2003_FFFC, 32'hA000_000E, 4'hF, K_DB,  16'hFFFF, 8'd3}, // R3 top capped ID
        '{32'h0801_0000, 32'h400,     XADDR,         32'hA000_000F, 4'hF, K_DB,  16'h0010, 8'd9}  // R9 window wins
    };

    task automatic chk(input bit ok, input int req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL R%0d %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Drive one write for a single cycle, return at the following negedge
    task automatic push(input logic [31:0] a, input logic [31:0] d, input logic [3:0] s);
        @(negedge clk);
        in_addr  = a;
        in_data  = d;
        in_strb  = s;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1 idle after reset
        chk(!db_valid && !byp_valid && !err_pulse, 1, "idle after reset",
            {db_valid, byp_valid, err_pulse}, 0);
        chk(in_ready, 1, "ready after reset", in_ready, 1);

        foreach (VECS[i]) begin
            cfg_win_base = VECS[i].base;
            cfg_win_size = VECS[i].size;
            push(VECS[i].addr, VECS[i].data, VECS[i].strb);
            case (VECS[i].kind)
                K_DB: begin
                    chk(db_valid && !byp_valid && !err_pulse, VECS[i].req, "doorbell route",
                        {db_valid, byp_valid, err_pulse}, 3'b100);
                    chk(db_devid == VECS[i].id, VECS[i].req, "device id", db_devid, VECS[i].id);
                    chk(db_data == VECS[i].data, VECS[i].req, "doorbell data", db_data, VECS[i].data);
                end
                K_BYP: begin
                    chk(!db_valid && byp_valid && !err_pulse, VECS[i].req, "bypass route",
                        {db_valid, byp_valid, err_pulse}, 3'b010);
                    chk({byp_addr, byp_data, byp_strb} == {VECS[i].addr, VECS[i].data, VECS[i].strb},
                        VECS[i].req, "bypass payload", {byp_addr, byp_data}, {VECS[i].addr, VECS[i].data});
                end
                default: begin
                    chk(!db_valid && !byp_valid && err_pulse, VECS[i].req, "error drop",
                        {db_valid, byp_valid, err_pulse}, 3'b001);
                end
            endcase
        end

        // R5 error pulse lasts one cycle only
        cfg_win_base = 32'h1000_0000;
        cfg_win_size = 32'h400;
        push(32'h1000_0021, 32'h1, 4'hF);
        @(negedge clk);
        chk(!err_pulse && !db_valid, 5, "error pulse width", err_pulse, 0);

        // R8 doorbell stall holds payload and blocks input
        db_ready = 1'b0;
        push(32'h1000_0008, 32'hCAFE_0001, 4'hF);
        chk(db_valid && db_devid == 16'h2, 8, "stalled doorbell present", db_devid, 16'h2);
        chk(!in_ready, 8, "input blocked by doorbell stall", in_ready, 0);
        repeat (3) @(negedge clk);
        chk(db_valid && db_data == 32'hCAFE_0001 && db_devid == 16'h2, 8, "doorbell held",
            db_data, 32'hCAFE_0001);
        db_ready = 1'b1;
        @(negedge clk);
        chk(!db_valid && in_ready, 8, "doorbell drained", {db_valid, in_ready}, 2'b01);

        // R8 bypass stall blocks input too
        byp_ready = 1'b0;
        push(32'h3000_0000, 32'hBEEF_0002, 4'h8);
        @(negedge clk);
        chk(byp_valid && byp_data == 32'hBEEF_0002 && !in_ready, 8, "bypass held, input blocked",
            {byp_valid, in_ready}, 2'b10);
        byp_ready = 1'b1;
        @(negedge clk);
        chk(!byp_valid, 8, "bypass drained", byp_valid, 0);

        // R2 back-to-back writes keep their own IDs
        push(32'h1000_0030, 32'h11, 4'hF);
        chk(db_devid == 16'hC, 2, "first of pair", db_devid, 16'hC);
        push(32'h1000_0034, 32'h22, 4'hF);
        chk(db_devid == 16'hD && db_data == 32'h22, 2, "second of pair", db_devid, 16'hD);

        // R1 reset mid-operation clears outputs
        db_ready = 1'b0;
        push(32'h1000_0004, 32'h33, 4'hF);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        db_ready = 1'b1;
        @(negedge clk);
        chk(!db_valid && !byp_valid && !err_pulse, 1, "outputs cleared by reset",
            {db_valid, byp_valid, err_pulse}, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule